// File: doc/BRIEF.md
# Ultra DMA Host Burst Initiator

This block sits on the host side of a parallel disk link and opens a read-direction Ultra DMA burst. It samples the device's DMA request line through a two-stage synchroniser. Once the request is seen and the host receive buffer has room for at least two words, it puts the interface into its pre-burst state in a single cycle: stop raised, host-ready negated, both chip selects and all three address lines negated. It then counts a programmable setup interval before asserting the active-low acknowledge. A second programmable count sets how long the host keeps driving the 16-bit data bus after acknowledge falls.

Acknowledge stays asserted until the surrounding logic pulses an end-of-burst input. Chip selects and address lines remain negated for one further cycle after that, and only then return to the register-access values supplied on the side inputs. The block also watches whether the device drops its request before the first falling edge of the device strobe, and keeps a sticky flag if it does. A command-level latch keeps only the first error code reported across all bursts of one command and presents it when the command ends.

Top module: `udma_burst_init`

## Requirements
- R1: After reset, acknowledge is high (negated), stop is low, the violation flag is low and the command-done pulse is low.
- R2: With space available, stop rises on the third rising clock edge after the request input goes high, because the request passes a two-flop synchroniser.
- R3: A burst start raises stop, drives host-ready-n high, drives chip-select-n to 2'b11 and drives address to 3'b000, all in the same cycle. These values hold for as long as acknowledge is low.
- R4: No burst starts while the free-word input is below 2. Once it reaches 2 with the request still high, stop rises on the next rising edge.
- R5: Acknowledge falls exactly max(T,1) cycles after stop rises, where T is the setup count input sampled at burst start.
- R6: The bus-drive output falls exactly Z cycles after acknowledge falls, where Z is the release count input; Z = 0 releases the bus on the same edge.
- R7: Acknowledge stays low until the end-of-burst input is sampled high in the burst state. An end-of-burst pulse during setup or release has no effect.
- R8: On the edge where acknowledge rises, chip-select-n stays 2'b11 and address stays 3'b000. The pass-through register-access values return one cycle later.
- R9: If the synchronised request falls after a burst start but before the first synchronised falling edge of the device strobe, a sticky violation flag rises. It clears only on command start. A request drop after that strobe edge raises no flag.
- R10: The error latch keeps the first error code after command start. Command end gives a one-cycle done pulse carrying that code and an error flag. With no error it carries code 0 and flag 0. An error arriving in the same cycle as command end counts if none came earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req_i | input | 1 | Device DMA request, asynchronous |
| dev_strobe_i | input | 1 | Device data strobe, asynchronous |
| free_words_i | input | FREE_W | Free words in the host receive buffer |
| tack_cycles_i | input | CNT_W | Setup count before acknowledge |
| taz_cycles_i | input | CNT_W | Cycles from acknowledge to bus release |
| end_burst_i | input | 1 | Ends the current burst |
| pio_cs_n_i | input | 2 | Chip-select-n value used outside bursts |
| pio_addr_i | input | 3 | Address value used outside bursts |
| cmd_start_i | input | 1 | Clears error latch and violation flag |
| cmd_end_i | input | 1 | Requests the command-end report |
| err_valid_i | input | 1 | An error occurred this cycle |
| err_code_i | input | ERR_W | Code of that error |
| stop_o | output | 1 | Stop line to the device |
| hrdy_n_o | output | 1 | Host ready, active low |
| cs_n_o | output | 2 | Chip selects, active low |
| addr_o | output | 3 | Register address lines |
| ack_n_o | output | 1 | DMA acknowledge, active low |
| bus_drive_o | output | 1 | 1 while the host may drive the data bus |
| burst_o | output | 1 | High while acknowledge is asserted |
| viol_o | output | 1 | Sticky request-protocol violation |
| done_o | output | 1 | One-cycle command-end pulse |
| done_err_o | output | 1 | An error was latched for this command |
| done_code_o | output | ERR_W | First error code of the command |

## Verification
The assertions assume that end-of-burst arrives only after the device has dropped its request, and that this drop has passed through the synchroniser. Without that, the one-cycle idle state would see a stale request and immediately open another burst. They also assume that the setup and release counts hold steady during a burst. The bench keeps within these limits: it changes the counts only between bursts, and in every burst it lowers the request and waits several cycles before pulsing end-of-burst. The violation case follows the same order and simply omits the strobe edge.

// File: rtl/udma_pkg.sv
package udma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_REQ,
    ST_SETUP,
    ST_ACK_TAZ,
    ST_BURST
  } udma_st_e;

  localparam logic [1:0] CS_OFF   = 2'b11;
  localparam logic [2:0] ADDR_OFF = 3'b000;
  localparam int         MIN_FREE = 2;
endpackage

// File: rtl/udma_sync.sv
module udma_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= '0;
    else     chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[s] <= '0;
      else     chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/udma_dn_cnt.sv
module udma_dn_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // last cycle of the interval: count of one or zero remaining
  assign last_o = (cnt_q <= W'(1));
endmodule

// File: rtl/udma_err_latch.sv
module udma_err_latch #(
  parameter int EW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          err_valid_i,
  input  logic [EW-1:0] err_code_i,
  input  logic          cmd_end_i,
  output logic          hold_valid_o,
  output logic [EW-1:0] hold_code_o,
  output logic          done_o,
  output logic          done_err_o,
  output logic [EW-1:0] done_code_o
);
  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      hold_valid_o <= 1'b0;
      hold_code_o  <= '0;
    end else if (err_valid_i && !hold_valid_o) begin
      hold_valid_o <= 1'b1;
      hold_code_o  <= err_code_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o      <= 1'b0;
      done_err_o  <= 1'b0;
      done_code_o <= '0;
    end else begin
      done_o <= cmd_end_i;
      if (cmd_end_i) begin
        done_err_o  <= hold_valid_o || err_valid_i;
        done_code_o <= hold_valid_o ? hold_code_o :
                       (err_valid_i ? err_code_i : '0);
      end
    end
  end
endmodule

// File: rtl/udma_burst_init.sv
module udma_burst_init
  import udma_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int FREE_W = 6,
  parameter int ERR_W  = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dev_req_i,
  input  logic              dev_strobe_i,
  input  logic [FREE_W-1:0] free_words_i,
  input  logic [CNT_W-1:0]  tack_cycles_i,
  input  logic [CNT_W-1:0]  taz_cycles_i,
  input  logic              end_burst_i,
  input  logic [1:0]        pio_cs_n_i,
  input  logic [2:0]        pio_addr_i,
  input  logic              cmd_start_i,
  input  logic              cmd_end_i,
  input  logic              err_valid_i,
  input  logic [ERR_W-1:0]  err_code_i,
  output logic              stop_o,
  output logic              hrdy_n_o,
  output logic [1:0]        cs_n_o,
  output logic [2:0]        addr_o,
  output logic              ack_n_o,
  output logic              bus_drive_o,
  output logic              burst_o,
  output logic              viol_o,
  output logic              done_o,
  output logic              done_err_o,
  output logic [ERR_W-1:0]  done_code_o
);
  localparam logic [FREE_W-1:0] FREE_MIN = FREE_W'(MIN_FREE);

  udma_st_e st_q, st_nx;

  logic [1:0] sync_w;
  logic       req_s, stb_s, stb_prev_q, stb_fall;
  logic       cnt_load, cnt_last;
  logic [CNT_W-1:0] cnt_val;
  logic       armed_q;
  logic       pre_nx, ack_nx, pio_ok, drive_nx;
  logic       err_hold_v;
  logic [ERR_W-1:0] err_hold_c;

  udma_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({dev_strobe_i, dev_req_i}),
    .q_o (sync_w)
  );
  assign req_s = sync_w[0];
  assign stb_s = sync_w[1];

  // one counter shared by the setup and release intervals
  udma_dn_cnt #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .last_o     (cnt_last)
  );

  always_comb begin
    st_nx    = st_q;
    cnt_load = 1'b0;
    cnt_val  = tack_cycles_i;
    unique case (st_q)
      ST_IDLE: st_nx = ST_WAIT_REQ;
      ST_WAIT_REQ: begin
        if (req_s && (free_words_i >= FREE_MIN)) begin
          st_nx    = ST_SETUP;
          cnt_load = 1'b1;
          cnt_val  = tack_cycles_i;
        end
      end
      ST_SETUP: begin
        if (cnt_last) begin
          if (taz_cycles_i == '0) begin
            st_nx = ST_BURST;
          end else begin
            st_nx    = ST_ACK_TAZ;
            cnt_load = 1'b1;
            cnt_val  = taz_cycles_i;
          end
        end
      end
      ST_ACK_TAZ: if (cnt_last) st_nx = ST_BURST;
      ST_BURST:   if (end_burst_i) st_nx = ST_IDLE;
      default:    st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_nx;
  end

  // registered interface outputs, computed from the next state
  assign pre_nx   = (st_nx == ST_SETUP) || (st_nx == ST_ACK_TAZ) || (st_nx == ST_BURST);
  assign ack_nx   = (st_nx == ST_ACK_TAZ) || (st_nx == ST_BURST);
  assign pio_ok   = ((st_q == ST_IDLE) || (st_q == ST_WAIT_REQ)) &&
                    ((st_nx == ST_IDLE) || (st_nx == ST_WAIT_REQ));
  assign drive_nx = !((st_nx == ST_BURST) || (st_q == ST_BURST));

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_o      <= 1'b0;
      hrdy_n_o    <= 1'b0;
      cs_n_o      <= CS_OFF;
      addr_o      <= ADDR_OFF;
      ack_n_o     <= 1'b1;
      bus_drive_o <= 1'b1;
      burst_o     <= 1'b0;
    end else begin
      stop_o      <= pre_nx;
      hrdy_n_o    <= pre_nx;
      cs_n_o      <= pio_ok ? pio_cs_n_i : CS_OFF;
      addr_o      <= pio_ok ? pio_addr_i : ADDR_OFF;
      ack_n_o     <= !ack_nx;
      bus_drive_o <= drive_nx;
      burst_o     <= ack_nx;
    end
  end

  // request must hold until the first falling strobe edge
  assign stb_fall = stb_prev_q && !stb_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_prev_q <= 1'b0;
      armed_q    <= 1'b0;
      viol_o     <= 1'b0;
    end else begin
      stb_prev_q <= stb_s;
      if (st_q == ST_WAIT_REQ && st_nx == ST_SETUP) armed_q <= 1'b1;
      else if (stb_fall || st_nx == ST_IDLE)         armed_q <= 1'b0;
      if (cmd_start_i)            viol_o <= 1'b0;
      else if (armed_q && !req_s) viol_o <= 1'b1;
    end
  end

  udma_err_latch #(.EW(ERR_W)) u_err (
    .clk          (clk),
    .rst          (rst),
    .clear_i      (cmd_start_i),
    .err_valid_i  (err_valid_i),
    .err_code_i   (err_code_i),
    .cmd_end_i    (cmd_end_i),
    .hold_valid_o (err_hold_v),
    .hold_code_o  (err_hold_c),
    .done_o       (done_o),
    .done_err_o   (done_err_o),
    .done_code_o  (done_code_o)
  );
endmodule

// File: rtl/udma_burst_init_chk.sv
module udma_burst_init_chk #(
  parameter int FREE_W = 6,
  parameter int ERR_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [FREE_W-1:0] free_words_i,
  input logic              end_burst_i,
  input logic              cmd_start_i,
  input logic              stop_o,
  input logic              hrdy_n_o,
  input logic [1:0]        cs_n_o,
  input logic [2:0]        addr_o,
  input logic              ack_n_o,
  input logic              hold_v,
  input logic [ERR_W-1:0]  hold_c
);
  // R3: while acknowledge is low the pre-burst state holds
  a_r3_pre_hold: assert property (@(posedge clk) disable iff (rst)
    !ack_n_o |-> (stop_o && hrdy_n_o && cs_n_o == 2'b11 && addr_o == 3'b000));

  // R4: a start only follows a sample showing room for two words
  a_r4_space: assert property (@(posedge clk) disable iff (rst)
    $rose(stop_o) |-> ($past(free_words_i) >= FREE_W'(2)));

  // R5: acknowledge falls only after the preconditions were already present
  a_r5_setup_first: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n_o) |-> ($past(stop_o) && $past(hrdy_n_o)));

  // R7: acknowledge rises only on a sampled end-of-burst
  a_r7_end_only: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_n_o) |-> $past(end_burst_i));

  // R8: selects and address still negated as acknowledge rises
  a_r8_cs_after: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_n_o) |-> (cs_n_o == 2'b11 && addr_o == 3'b000));

  // R10: once held, the first error code does not change until cleared
  a_r10_first_kept: assert property (@(posedge clk) disable iff (rst)
    (hold_v && !cmd_start_i) |=> (hold_v && $stable(hold_c)));
endmodule

bind udma_burst_init udma_burst_init_chk #(.FREE_W(FREE_W), .ERR_W(ERR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .free_words_i (free_words_i),
  .end_burst_i  (end_burst_i),
  .cmd_start_i  (cmd_start_i),
  .stop_o       (stop_o),
  .hrdy_n_o     (hrdy_n_o),
  .cs_n_o       (cs_n_o),
  .addr_o       (addr_o),
  .ack_n_o      (ack_n_o),
  .hold_v       (err_hold_v),
  .hold_c       (err_hold_c)
);

// File: tb/sim_udma_burst_init.sv
module sim_udma_burst_init;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dev_req_i = 0, dev_strobe_i = 0;
  logic [5:0] free_words_i = 6'd8;
  logic [7:0] tack_cycles_i = 8'd3, taz_cycles_i = 8'd2;
  logic       end_burst_i = 0;
  logic [1:0] pio_cs_n_i = 2'b01;
  logic [2:0] pio_addr_i = 3'b101;
  logic       cmd_start_i = 0, cmd_end_i = 0, err_valid_i = 0;
  logic [3:0] err_code_i = 0;
  logic       stop_o, hrdy_n_o, ack_n_o, bus_drive_o, burst_o, viol_o;
  logic       done_o, done_err_o;
  logic [1:0] cs_n_o;
  logic [2:0] addr_o;
  logic [3:0] done_code_o;

  int total = 0;
  int bad   = 0;
  bit fin   = 0;

  always #2 clk = ~clk;

  udma_burst_init u0 (
    .clk(clk), .rst(rst), .dev_req_i(dev_req_i), .dev_strobe_i(dev_strobe_i),
    .free_words_i(free_words_i), .tack_cycles_i(tack_cycles_i),
    .taz_cycles_i(taz_cycles_i), .end_burst_i(end_burst_i),
    .pio_cs_n_i(pio_cs_n_i), .pio_addr_i(pio_addr_i),
    .cmd_start_i(cmd_start_i), .cmd_end_i(cmd_end_i),
    .err_valid_i(err_valid_i), .err_code_i(err_code_i),
    .stop_o(stop_o), .hrdy_n_o(hrdy_n_o), .cs_n_o(cs_n_o), .addr_o(addr_o),
    .ack_n_o(ack_n_o), .bus_drive_o(bus_drive_o), .burst_o(burst_o),
    .viol_o(viol_o), .done_o(done_o), .done_err_o(done_err_o),
    .done_code_o(done_code_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_stop(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!stop_o && n < 40);
  endtask

  task automatic wait_ack(output int n);
    n = 0;
    while (ack_n_o && n < 60) begin @(negedge clk); n++; end
  endtask

  task automatic wait_rel(output int n);
    n = 0;
    while (bus_drive_o && n < 60) begin @(negedge clk); n++; end
  endtask

  // legal close: strobe edge, request drop, then end of burst
  task automatic finish_burst();
    dev_strobe_i = 1; cyc(3);
    dev_strobe_i = 0; cyc(4);
    dev_req_i = 0; cyc(4);
    end_burst_i = 1; @(negedge clk); end_burst_i = 0;
    cyc(3);
  endtask

  task automatic t_reset();
    chk(ack_n_o == 1'b1, "R1 ack after reset", ack_n_o, 1);
    chk(stop_o == 1'b0, "R1 stop after reset", stop_o, 0);
    chk(viol_o == 1'b0 && done_o == 1'b0, "R1 flags after reset", {viol_o, done_o}, 0);
  endtask

  task automatic t_basic(input int tack, input int taz);
    int n;
    int want;
    tack_cycles_i = 8'(tack); taz_cycles_i = 8'(taz); free_words_i = 6'd8;
    dev_req_i = 1;
    wait_stop(n);
    chk(n == 3, "R2 sync latency", n, 3);
    chk(hrdy_n_o && cs_n_o == 2'b11 && addr_o == 3'b000, "R3 pre-burst state",
        {hrdy_n_o, cs_n_o, addr_o}, 6'b111000);
    wait_ack(n);
    want = (tack < 1) ? 1 : tack;
    chk(n == want, "R5 setup interval", n, want);
    wait_rel(n);
    chk(n == taz, "R6 bus release", n, taz);
    dev_strobe_i = 1; cyc(3);
    dev_strobe_i = 0; cyc(4);
    dev_req_i = 0; cyc(4);
    chk(ack_n_o == 1'b0, "R7 ack held in burst", ack_n_o, 0);
    chk(viol_o == 1'b0, "R9 clean drop no flag", viol_o, 0);
    end_burst_i = 1; @(negedge clk); end_burst_i = 0;
    chk(ack_n_o == 1'b1, "R7 ack rises on end", ack_n_o, 1);
    chk(cs_n_o == 2'b11 && addr_o == 3'b000, "R8 negated at ack rise", {cs_n_o, addr_o}, 5'b11000);
    @(negedge clk);
    chk(cs_n_o == pio_cs_n_i && addr_o == pio_addr_i, "R8 pio restored",
        {cs_n_o, addr_o}, {pio_cs_n_i, pio_addr_i});
    cyc(3);
  endtask

  task automatic t_space();
    int n;
    tack_cycles_i = 8'd1; taz_cycles_i = 8'd1;
    free_words_i = 6'd1;
    dev_req_i = 1;
    cyc(10);
    chk(stop_o == 1'b0, "R4 blocked at one free word", stop_o, 0);
    free_words_i = 6'd2;
    wait_stop(n);
    chk(n == 1, "R4 starts at two free words", n, 1);
    wait_ack(n);
    wait_rel(n);
    finish_burst();
    free_words_i = 6'd8;
  endtask

  task automatic t_ignore();
    int n;
    tack_cycles_i = 8'd6; taz_cycles_i = 8'd2;
    dev_req_i = 1;
    wait_stop(n);
    end_burst_i = 1; @(negedge clk); end_burst_i = 0;
    @(negedge clk);
    wait_ack(n);
    n = n + 2;
    chk(n == 6, "R7 end ignored in setup", n, 6);
    cyc(5);
    chk(ack_n_o == 1'b0, "R7 ack still low after ignored end", ack_n_o, 0);
    finish_burst();
  endtask

  task automatic t_viol();
    int n;
    tack_cycles_i = 8'd1; taz_cycles_i = 8'd0;
    dev_req_i = 1;
    wait_stop(n);
    wait_ack(n);
    chk(bus_drive_o == 1'b0, "R6 zero release count", bus_drive_o, 0);
    dev_req_i = 0; cyc(4);
    chk(viol_o == 1'b1, "R9 early drop flagged", viol_o, 1);
    end_burst_i = 1; @(negedge clk); end_burst_i = 0;
    cyc(4);
    chk(viol_o == 1'b1, "R9 flag sticky", viol_o, 1);
    cmd_start_i = 1; @(negedge clk); cmd_start_i = 0;
    chk(viol_o == 1'b0, "R9 cleared by command start", viol_o, 0);
  endtask

  task automatic t_err();
    cmd_start_i = 1; @(negedge clk); cmd_start_i = 0;
    err_valid_i = 1; err_code_i = 4'd5; @(negedge clk); err_valid_i = 0;
    cyc(2);
    err_valid_i = 1; err_code_i = 4'd9; @(negedge clk); err_valid_i = 0;
    cmd_end_i = 1; @(negedge clk); cmd_end_i = 0;
    chk(done_o && done_err_o && done_code_o == 4'd5, "R10 first error kept",
        {done_o, done_err_o, done_code_o}, {2'b11, 4'd5});
    @(negedge clk);
    chk(done_o == 1'b0, "R10 done is one pulse", done_o, 0);
    cmd_start_i = 1; @(negedge clk); cmd_start_i = 0;
    cmd_end_i = 1; @(negedge clk); cmd_end_i = 0;
    chk(done_o && !done_err_o && done_code_o == 4'd0, "R10 clean command",
        {done_o, done_err_o, done_code_o}, {2'b10, 4'd0});
    cmd_start_i = 1; @(negedge clk); cmd_start_i = 0;
    cmd_end_i = 1; err_valid_i = 1; err_code_i = 4'd3;
    @(negedge clk); cmd_end_i = 0; err_valid_i = 0;
    chk(done_err_o && done_code_o == 4'd3, "R10 error with end",
        {done_err_o, done_code_o}, {1'b1, 4'd3});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    cyc(2);
    t_basic(3, 2);
    t_basic(0, 1);
    t_basic(5, 0);
    t_space();
    t_ignore();
    t_viol();
    t_err();
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule